// File: doc/BRIEF.md
# Endpoint Buffer-Ready Status and Interrupt

This block keeps one buffer-ready status flag for each of the six data endpoints of a USB device controller. Each flag is raised or dropped on edges of that endpoint's buffer-valid indication. The edges that count depend on three things: the endpoint's transfer direction, a global clear-mode select, and whether the endpoint is the one assigned to DMA. For the DMA endpoint, a per-endpoint interrupt-mode bit decides whether the flag is suppressed or is raised only when a short packet has been fully drained.

Software clears status flags through a small write port, which also loads the per-endpoint interrupt enables. A per-endpoint buffer-clear command forces the internal view of the valid indication low at once. That low view is held until the external valid signal itself falls. A single active-high interrupt line reports any enabled, set flag.

The block has no streaming data path: all pins are plain control and status levels or single-cycle pulses, so no valid/ready handshake and no back-pressure apply.

Top module: `epbuf_ready_irq`

## Requirements
- R1: Status bit k of `rdy_stat` belongs to endpoint k+1 (k = 0..5). Each bit evolves only from its own endpoint's inputs, plus the shared mode, DMA-select and write-port inputs.
- R2: With `ep_dir[k]`=0 (OUT), bit k is set by the clock edge at which the effective valid of endpoint k is 1 and was 0 at the previous edge. The set is visible right after that edge.
- R3: For an OUT endpoint with `sw_clr_mode`=0, a 1-to-0 change of the effective valid clears bit k at that edge. With `sw_clr_mode`=1, valid edges never clear it.
- R4: With `ep_dir[k]`=1 (IN), bit k is set by a 1-to-0 change of the effective valid. It is also set by a 0-to-1 change of `ep_dir[k]` between consecutive edges.
- R5: For an IN endpoint with `sw_clr_mode`=0, a 0-to-1 change of the effective valid clears bit k. With `sw_clr_mode`=1, valid edges never clear it.
- R6: A write with `wr_en`=1 and `wr_sel`=0 clears each status bit whose `wr_data` bit is 0, in either clear mode. Status bits whose `wr_data` bit is 1 are left unchanged.
- R7: If a set event and any clear event for the same bit land at the same edge, the set wins and the bit is 1 after the edge.
- R8: If `dma_sel` equals k+1 and `dma_irq_mode[k]`=1, bit k is never set. A `dma_sel` value of 0 selects no endpoint.
- R9: If `dma_sel` equals k+1 and `dma_irq_mode[k]`=0, bit k is set only by a `short_done[k]` pulse while the endpoint is OUT. Valid and direction edges do not set it, and as an IN endpoint it is never set. `short_done` has no effect on endpoints that are not DMA-selected.
- R10: A `buf_clr[k]` pulse forces the effective valid of endpoint k to 0 in the same cycle. The effective valid stays 0 until `buf_valid[k]` has been 0 at a clock edge. All valid edges are taken on the effective valid.
- R11: A write with `wr_en`=1 and `wr_sel`=1 loads the interrupt enables from `wr_data`. `irq` is 1 exactly when some status bit and its enable are both 1.
- R12: A synchronous `rst` clears all status bits, all enables, the buffer-clear hold and the edge history. After reset, an input already at 1 counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| buf_valid | input | 6 | Buffer-valid level per endpoint |
| ep_dir | input | 6 | Direction per endpoint, 1 = IN |
| short_done | input | 6 | Pulse: short packet fully read out |
| sw_clr_mode | input | 1 | 0 = automatic clear on valid edge, 1 = software clear only |
| dma_sel | input | 3 | DMA endpoint number, 0 = none |
| dma_irq_mode | input | 6 | Per-endpoint DMA interrupt mode, 1 = suppress |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = status clear, 1 = enable load |
| wr_data | input | 6 | Write data |
| buf_clr | input | 6 | Pulse: buffer-clear command per endpoint |
| rdy_stat | output | 6 | Buffer-ready status bits |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench builds the block with its default of six endpoints, so `dma_sel` spans all six endpoint numbers plus the idle code 0. Every endpoint can therefore be taken in and out of DMA service during random runs. With this width, the random phase reaches simultaneous set and clear events on several endpoints at once, and direction flips under an active buffer-clear hold. It also reaches mode changes while flags are pending.

// File: rtl/epr_pkg.sv
package epr_pkg;
  typedef enum logic {
    WSEL_STATUS = 1'b0,
    WSEL_ENABLE = 1'b1
  } wsel_e;
endpackage

// File: rtl/epr_hist.sv
module epr_hist #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= cur;
  end
endmodule

// File: rtl/epr_clr_hold.sv
module epr_clr_hold #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_valid,
  input  logic [W-1:0] clr_cmd,
  output logic [W-1:0] eff_valid
);
  logic [W-1:0] hold_q;

  // Forced low from the command cycle until the raw flag has dropped.
  assign eff_valid = raw_valid & ~(hold_q | clr_cmd);

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= clr_cmd | (hold_q & raw_valid);
  end
endmodule

// File: rtl/epr_ep_cell.sv
module epr_ep_cell (
  input  logic clk,
  input  logic rst,
  input  logic is_in,
  input  logic v_rise,
  input  logic v_fall,
  input  logic d_rise,
  input  logic dma_hit,
  input  logic dma_quiet,
  input  logic short_pulse,
  input  logic sw_mode,
  input  logic sw_clear,
  output logic ready
);
  logic set_plain, set_ev, auto_clr, clr_ev;

  always_comb begin
    set_plain = is_in ? (v_fall | d_rise) : v_rise;
    if (dma_hit) set_ev = dma_quiet ? 1'b0 : (~is_in & short_pulse);
    else         set_ev = set_plain;
    auto_clr = ~sw_mode & (is_in ? v_rise : v_fall);
    clr_ev   = auto_clr | sw_clear;
  end

  always_ff @(posedge clk) begin
    if (rst)         ready <= 1'b0;
    else if (set_ev) ready <= 1'b1;
    else if (clr_ev) ready <= 1'b0;
  end
endmodule

// File: rtl/epbuf_ready_irq.sv
module epbuf_ready_irq #(
  parameter int NUM_EP = 6,
  localparam int SEL_W = $clog2(NUM_EP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] buf_valid,
  input  logic [NUM_EP-1:0] ep_dir,
  input  logic [NUM_EP-1:0] short_done,
  input  logic              sw_clr_mode,
  input  logic [SEL_W-1:0]  dma_sel,
  input  logic [NUM_EP-1:0] dma_irq_mode,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [NUM_EP-1:0] wr_data,
  input  logic [NUM_EP-1:0] buf_clr,
  output logic [NUM_EP-1:0] rdy_stat,
  output logic              irq
);
  import epr_pkg::*;

  logic [NUM_EP-1:0] vld_eff, vld_prev, dir_prev;
  logic [NUM_EP-1:0] v_rise, v_fall, d_rise, sw_clr, dma_hit;
  logic [NUM_EP-1:0] en_q;
  logic              wr_stat, wr_en_reg;

  epr_clr_hold #(.W(NUM_EP)) u_hold (
    .clk(clk), .rst(rst), .raw_valid(buf_valid), .clr_cmd(buf_clr), .eff_valid(vld_eff)
  );

  epr_hist #(.W(NUM_EP)) u_vhist (.clk(clk), .rst(rst), .cur(vld_eff), .prev(vld_prev));
  epr_hist #(.W(NUM_EP)) u_dhist (.clk(clk), .rst(rst), .cur(ep_dir),  .prev(dir_prev));

  assign v_rise    = vld_eff & ~vld_prev;
  assign v_fall    = ~vld_eff & vld_prev;
  assign d_rise    = ep_dir & ~dir_prev;
  assign wr_stat   = wr_en & (wsel_e'(wr_sel) == WSEL_STATUS);
  assign wr_en_reg = wr_en & (wsel_e'(wr_sel) == WSEL_ENABLE);
  assign sw_clr    = {NUM_EP{wr_stat}} & ~wr_data;

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    assign dma_hit[k] = (dma_sel == SEL_W'(k + 1));
    epr_ep_cell u_cell (
      .clk(clk), .rst(rst),
      .is_in(ep_dir[k]), .v_rise(v_rise[k]), .v_fall(v_fall[k]), .d_rise(d_rise[k]),
      .dma_hit(dma_hit[k]), .dma_quiet(dma_irq_mode[k]), .short_pulse(short_done[k]),
      .sw_mode(sw_clr_mode), .sw_clear(sw_clr[k]), .ready(rdy_stat[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)            en_q <= '0;
    else if (wr_en_reg) en_q <= wr_data;
  end

  assign irq = |(rdy_stat & en_q);
endmodule

// File: rtl/epr_chk.sv
module epr_chk #(
  parameter int NUM_EP = 6,
  localparam int SEL_W = $clog2(NUM_EP + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_EP-1:0] ep_dir,
  input logic [NUM_EP-1:0] vld_eff,
  input logic [SEL_W-1:0]  dma_sel,
  input logic [NUM_EP-1:0] dma_irq_mode,
  input logic [NUM_EP-1:0] rdy_stat,
  input logic              irq
);
  a_r12_reset_clears: assert property (@(posedge clk) rst |=> (rdy_stat == '0));

  a_r11_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rdy_stat != '0));

  for (genvar k = 0; k < NUM_EP; k++) begin : g_k
    logic hit;
    assign hit = (dma_sel == SEL_W'(k + 1));

    a_r2_out_set_on_rise: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !ep_dir[k] && !hit && $rose(vld_eff[k])) |=> rdy_stat[k]);

    a_r4_in_set_on_fall_or_dir: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ep_dir[k] && !hit && ($fell(vld_eff[k]) || $rose(ep_dir[k])))
      |=> rdy_stat[k]);

    a_r8_dma_quiet_no_set: assert property (@(posedge clk) disable iff (rst)
      (hit && dma_irq_mode[k] && !rdy_stat[k]) |=> !rdy_stat[k]);

    a_r9_dma_in_no_set: assert property (@(posedge clk) disable iff (rst)
      (hit && !dma_irq_mode[k] && ep_dir[k] && !rdy_stat[k]) |=> !rdy_stat[k]);
  end
endmodule

bind epbuf_ready_irq epr_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst(rst), .ep_dir(ep_dir), .vld_eff(vld_eff), .dma_sel(dma_sel),
  .dma_irq_mode(dma_irq_mode), .rdy_stat(rdy_stat), .irq(irq)
);

// File: tb/epbuf_ready_irq_tb.sv
`timescale 1ns/1ps
module epbuf_ready_irq_tb;
  localparam int N = 6;
  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] buf_valid, ep_dir, short_done, dma_irq_mode, wr_data, buf_clr, rdy_stat;
  logic sw_clr_mode, wr_en, wr_sel, irq;
  logic [2:0] dma_sel;
  int errors = 0, checks = 0;

  logic [N-1:0] m_rdy, m_en, m_vp, m_dp, m_hold;

  always #2.5 clk = ~clk;

  epbuf_ready_irq u_dut (
    .clk(clk), .rst(rst), .buf_valid(buf_valid), .ep_dir(ep_dir), .short_done(short_done),
    .sw_clr_mode(sw_clr_mode), .dma_sel(dma_sel), .dma_irq_mode(dma_irq_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .buf_clr(buf_clr),
    .rdy_stat(rdy_stat), .irq(irq)
  );

  // Expected state after the coming edge, from the requirements.
  function automatic void model_step();
    logic [N-1:0] ev, vr, vf, dr, nrdy;
    if (rst) begin
      m_rdy = '0; m_en = '0; m_vp = '0; m_dp = '0; m_hold = '0;
      return;
    end
    ev = buf_valid & ~(m_hold | buf_clr);
    vr = ev & ~m_vp; vf = ~ev & m_vp; dr = ep_dir & ~m_dp;
    nrdy = m_rdy;
    for (int k = 0; k < N; k++) begin
      logic s, c;
      if (dma_sel == 3'(k + 1)) s = !dma_irq_mode[k] && !ep_dir[k] && short_done[k];
      else s = ep_dir[k] ? (vf[k] | dr[k]) : vr[k];
      c = (!sw_clr_mode && (ep_dir[k] ? vr[k] : vf[k])) || (wr_en && !wr_sel && !wr_data[k]);
      if (s) nrdy[k] = 1'b1;
      else if (c) nrdy[k] = 1'b0;
    end
    m_rdy = nrdy;
    if (wr_en && wr_sel) m_en = wr_data;
    m_hold = buf_clr | (m_hold & buf_valid);
    m_vp = ev; m_dp = ep_dir;
  endfunction

  task automatic check(string req);
    checks++;
    if (rdy_stat !== m_rdy || irq !== |(m_rdy & m_en)) begin
      errors++;
      $display("FAIL %s rdy=%b exp=%b irq=%b exp=%b", req, rdy_stat, m_rdy, irq, |(m_rdy & m_en));
    end
  endtask

  task automatic step(string req);
    model_step();
    @(negedge clk);
    check(req);
    short_done = '0; buf_clr = '0; wr_en = 1'b0;
  endtask

  task automatic wr(logic sel, logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; buf_valid = '0; ep_dir = '0; short_done = '0; dma_irq_mode = '0;
    wr_data = '0; buf_clr = '0; sw_clr_mode = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; dma_sel = '0;
    @(negedge clk);
    step("R12 reset");
    rst = 1'b0;
    wr(1'b1, '1); step("R11 enable load");

    // R2 / R3 on EP1 (OUT)
    buf_valid[0] = 1'b1; step("R2 out set");
    buf_valid[0] = 1'b0; step("R3 auto clear");
    sw_clr_mode = 1'b1;
    buf_valid[0] = 1'b1; step("R2 set sw mode");
    buf_valid[0] = 1'b0; step("R3 sw mode holds");
    wr(1'b0, '1); step("R6 write one no effect");
    wr(1'b0, 6'b111110); step("R6 write zero clears");

    // R4 / R5 on EP2 (IN)
    sw_clr_mode = 1'b0;
    ep_dir[1] = 1'b1; step("R4 dir rise sets");
    buf_valid[1] = 1'b1; step("R5 auto clear on rise");
    buf_valid[1] = 1'b0; step("R4 set on fall");
    sw_clr_mode = 1'b1;
    buf_valid[1] = 1'b1; step("R5 sw mode holds");
    wr(1'b0, 6'b111101); step("R6 clear IN bit");

    // R7: set and software clear in the same cycle on EP3
    buf_valid[2] = 1'b1; wr(1'b0, '0); step("R7 set wins");

    // R8 / R9 on EP4 as the DMA endpoint
    sw_clr_mode = 1'b0; dma_sel = 3'd4; dma_irq_mode[3] = 1'b1;
    buf_valid[3] = 1'b1; step("R8 no set on rise");
    short_done[3] = 1'b1; step("R8 no set on short");
    dma_irq_mode[3] = 1'b0; buf_valid[3] = 1'b0; step("R9 step");
    buf_valid[3] = 1'b1; step("R9 valid rise ignored");
    short_done[3] = 1'b1; step("R9 short sets");
    short_done[4] = 1'b1; step("R9 short on other ep ignored");
    buf_clr[3] = 1'b1; step("R10 clear on dma ep");
    dma_sel = 3'd0;

    // R10 on EP6 (OUT, auto mode)
    buf_valid[5] = 1'b1; step("R10 setup set");
    buf_clr[5] = 1'b1; step("R10 forced fall clears");
    step("R10 held low no rise");
    buf_valid[5] = 1'b0; step("R10 release");
    buf_valid[5] = 1'b1; step("R10 rise after release");

    // R11 enable masking
    wr(1'b1, '0); step("R11 irq masked");
    wr(1'b1, 6'b100000); step("R11 irq one enable");

    // R12 mid-run reset
    rst = 1'b1; step("R12 reset mid-run");
    rst = 1'b0; step("R12 level after reset counts as rise");

    // R1 random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) buf_valid ^= N'(1 << $urandom_range(N - 1));
      if ($urandom_range(15) == 0) ep_dir ^= N'(1 << $urandom_range(N - 1));
      if ($urandom_range(3) == 0) short_done = N'($urandom);
      if ($urandom_range(15) == 0) buf_clr = N'(1 << $urandom_range(N - 1));
      if ($urandom_range(63) == 0) sw_clr_mode = ~sw_clr_mode;
      if ($urandom_range(31) == 0) dma_sel = 3'($urandom_range(N));
      if ($urandom_range(31) == 0) dma_irq_mode = N'($urandom);
      if ($urandom_range(7) == 0) wr(1'($urandom), N'($urandom));
      rst = ($urandom_range(999) == 0);
      step("R1 random");
    end
    rst = 1'b0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule